// File: doc/BRIEF.md
# Dual-Mode Programmable-Flag FIFO

This block is a first-in first-out buffer with independent write and read clocks. The two clocks may be the same net or fully unrelated. A master reset picks one of two read behaviours. In standard mode every word needs a read request before it shows on the output. In fall-through mode the oldest stored word is placed on the output by itself, and a read request only consumes it. The same reset also picks a default distance for the almost-empty and almost-full thresholds.

Write and read pointers cross between the clock domains as Gray codes, each through a two-flop synchronizer. The read-side status and the almost-empty flag are computed in the read domain. The write-side status, the half-full flag and the almost-full flag are computed in the write domain. After reset, the almost-empty offset can be reloaded through a parallel strobe on the read clock, and the almost-full offset through a parallel strobe on the write clock.

Top module: `dmf_fifo`

## Requirements
- R1: A word on `wr_data` is stored on each rising `wr_clk` edge where `wr_en` is high and the FIFO is not full. Writes attempted while full are dropped, and the stored contents stay unchanged.
- R2: Words leave in the order they were accepted, with no loss and no duplication. This holds whether `rd_clk` is the same clock as `wr_clk` or runs at an unrelated rate.
- R3: Standard mode (`fwft_sel` low at reset). A read is accepted on a rising `rd_clk` edge where `rd_en` is high and `stat_rd` is low. The word appears on `rd_data` after that edge. A read request while empty changes neither `rd_data` nor the read position.
- R4: Fall-through mode (`fwft_sel` high at reset). The oldest stored word is driven on `rd_data` with `stat_rd` high, without any read request. `rd_en` high consumes it. `rd_en` while `stat_rd` is low is ignored.
- R5: `stat_rd` and `stat_wr` change meaning with the latched mode. In standard mode, `stat_rd` high means empty and `stat_wr` high means full. In fall-through mode, `stat_rd` high means a valid word is on `rd_data` and `stat_wr` high means there is room for a write.
- R6: `half_full` is high exactly when the stored word count is greater than DEPTH/2, in either mode.
- R7: `almost_empty` is high when the stored count is at most the empty-side offset. `almost_full` is high when the stored count is at least DEPTH minus the full-side offset. In fall-through mode the word held on `rd_data` counts as stored.
- R8: At master reset, `def_sel` low sets both offsets to 127 and `def_sel` high sets both to 1023.
- R9: A high `ae_ld` at a rising `rd_clk` edge replaces the empty-side offset with `ae_val`. A high `af_ld` at a rising `wr_clk` edge replaces the full-side offset with `af_val`. The new values decide the flags from then on.
- R10: `mrst` is asynchronous and active high. It empties the FIFO and drives `half_full` and `almost_full` low. It drives `stat_rd` high in standard mode and low in fall-through mode, and drives `stat_wr` low in standard mode and high in fall-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst | input | 1 | Asynchronous master reset, active high |
| fwft_sel | input | 1 | Mode sampled during reset: 1 selects fall-through, 0 selects standard |
| def_sel | input | 1 | Default offset sampled during reset: 1 selects 1023, 0 selects 127 |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Read data |
| stat_rd | output | 1 | Empty (standard mode) or output valid (fall-through mode) |
| stat_wr | output | 1 | Full (standard mode) or room available (fall-through mode) |
| half_full | output | 1 | Stored count above DEPTH/2 |
| almost_empty | output | 1 | Stored count at or below the empty-side offset |
| almost_full | output | 1 | Stored count at or above DEPTH minus the full-side offset |
| ae_ld | input | 1 | Load strobe for the empty-side offset, read clock |
| ae_val | input | AW | New empty-side offset |
| af_ld | input | 1 | Load strobe for the full-side offset, write clock |
| af_val | input | AW | New full-side offset |

## Verification
The interesting coincidence is a write and a read landing on the same edge while the stored count sits on a flag threshold. A correct design counts the word that leaves and the word that arrives without double-counting either. The bench provokes this by holding the count at the half-full point and running concurrent write and read streams. It does so again with the two clocks at unrelated periods, in both modes. Every word read is compared against a queue model. After each burst the flags are compared with values derived from the queue's length.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } dmf_mode_e;

endpackage

// File: rtl/dmf_sync2.sv
module dmf_sync2 #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         mrst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/dmf_ram.sv
module dmf_ram #(
    parameter int DW = 18,
    parameter int AW = 11
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dmf_wr_ctl.sv
module dmf_wr_ctl
    import dmf_pkg::*;
#(
    parameter int AW     = 11,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic          wclk,
    input  logic          mrst,
    input  logic          fwft_sel,
    input  logic          def_sel,
    input  logic          wen,
    input  logic          af_ld,
    input  logic [AW-1:0] af_val,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          stat_wr,
    output logic          half_full,
    output logic          almost_full
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          hf;
        logic          af;
    } wst_t;

    typedef struct packed {
        dmf_mode_e     mode;
        logic [AW-1:0] off;
    } wcfg_t;

    localparam wst_t WST_RST = '{bin: '0, gray: '0, full: 1'b0, hf: 1'b0, af: 1'b0};

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wst_t          st_q, st_d;
    wcfg_t         cfg_q, cfg_d;
    logic          acc;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] cnt;

    always_comb begin
        cfg_d = cfg_q;
        if (mrst) begin
            cfg_d.mode = dmf_mode_e'(fwft_sel);
            cfg_d.off  = def_sel ? AW'(DEF_HI) : AW'(DEF_LO);
        end else if (af_ld) begin
            cfg_d.off = af_val;
        end

        acc     = wen && !st_q.full;
        st_d    = st_q;
        st_d.bin  = st_q.bin + PW'(acc);
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        rbin_s  = gray2bin(rgray_s);
        cnt     = st_d.bin - rbin_s;
        st_d.full = (cnt == DEPTH_P);
        st_d.hf   = (cnt > HALF_P);
        st_d.af   = (cnt >= (DEPTH_P - PW'(cfg_q.off)));
    end

    always_ff @(posedge wclk) begin
        cfg_q <= cfg_d;
    end

    always_ff @(posedge wclk or posedge mrst) begin
        if (mrst) st_q <= WST_RST;
        else      st_q <= st_d;
    end

    assign we          = acc;
    assign waddr       = st_q.bin[AW-1:0];
    assign wgray       = st_q.gray;
    assign stat_wr     = (cfg_q.mode == MODE_FWFT) ? !st_q.full : st_q.full;
    assign half_full   = st_q.hf;
    assign almost_full = st_q.af;

    // R1: a full buffer holds its write position
    a_r1_full_holds_ptr: assert property (@(posedge wclk) disable iff (mrst)
        st_q.full |=> (st_q.bin == $past(st_q.bin)));

    // R1: at most one word accepted per edge
    a_r1_single_step: assert property (@(posedge wclk) disable iff (mrst)
        (st_q.bin - $past(st_q.bin)) <= PW'(1));

    // R2: the crossing pointer changes one bit at a time
    a_r2_wgray_one_bit: assert property (@(posedge wclk) disable iff (mrst)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);

    // R6: full implies both upper flags
    a_r6_full_implies_upper: assert property (@(posedge wclk) disable iff (mrst)
        st_q.full |-> (st_q.hf && st_q.af));
endmodule

// File: rtl/dmf_rd_ctl.sv
module dmf_rd_ctl
    import dmf_pkg::*;
#(
    parameter int DW     = 18,
    parameter int AW     = 11,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic          rclk,
    input  logic          mrst,
    input  logic          fwft_sel,
    input  logic          def_sel,
    input  logic          ren,
    input  logic          ae_ld,
    input  logic [AW-1:0] ae_val,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   relgray,
    output logic [DW-1:0] dout,
    output logic          stat_rd,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] rbin;
        logic [PW-1:0] relbin;
        logic [PW-1:0] relgray;
        logic          valid;
        logic [DW-1:0] dout;
        logic          empty;
        logic          ae;
    } rst_t;

    typedef struct packed {
        dmf_mode_e     mode;
        logic [AW-1:0] off;
    } rcfg_t;

    localparam rst_t RST_RST = '{rbin: '0, relbin: '0, relgray: '0, valid: 1'b0,
                                 dout: '0, empty: 1'b1, ae: 1'b1};

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    rst_t          st_q, st_d;
    rcfg_t         cfg_q, cfg_d;
    logic [PW-1:0] wbin_s;
    logic          take;
    logic          load;

    always_comb begin
        cfg_d = cfg_q;
        if (mrst) begin
            cfg_d.mode = dmf_mode_e'(fwft_sel);
            cfg_d.off  = def_sel ? AW'(DEF_HI) : AW'(DEF_LO);
        end else if (ae_ld) begin
            cfg_d.off = ae_val;
        end

        wbin_s = gray2bin(wgray_s);
        st_d   = st_q;
        take   = 1'b0;
        load   = 1'b0;
        if (cfg_q.mode == MODE_FWFT) begin
            take        = ren && st_q.valid;
            load        = (wbin_s != st_q.rbin) && (!st_q.valid || take);
            st_d.valid  = load || (st_q.valid && !take);
            st_d.relbin = st_q.relbin + PW'(take);
        end else begin
            load        = ren && !st_q.empty;
            st_d.relbin = st_q.relbin + PW'(load);
        end
        st_d.rbin = st_q.rbin + PW'(load);
        if (load) st_d.dout = rdata;
        st_d.relgray = st_d.relbin ^ (st_d.relbin >> 1);
        st_d.empty   = (wbin_s == st_d.rbin);
        st_d.ae      = ((wbin_s - st_d.relbin) <= PW'(cfg_q.off));
    end

    always_ff @(posedge rclk) begin
        cfg_q <= cfg_d;
    end

    always_ff @(posedge rclk or posedge mrst) begin
        if (mrst) st_q <= RST_RST;
        else      st_q <= st_d;
    end

    assign raddr        = st_q.rbin[AW-1:0];
    assign relgray      = st_q.relgray;
    assign dout         = st_q.dout;
    assign stat_rd      = (cfg_q.mode == MODE_FWFT) ? st_q.valid : st_q.empty;
    assign almost_empty = st_q.ae;

    // R3: no read position change while empty in standard mode
    a_r3_empty_holds_ptr: assert property (@(posedge rclk) disable iff (mrst)
        (cfg_q.mode == MODE_STD && st_q.empty) |=> (st_q.rbin == $past(st_q.rbin)));

    // R4: a presented word stays until consumed
    a_r4_word_held: assert property (@(posedge rclk) disable iff (mrst)
        (cfg_q.mode == MODE_FWFT && st_q.valid && !ren) |=> (st_q.valid && $stable(st_q.dout)));

    // R4: nothing is released while no word is presented
    a_r4_no_release_idle: assert property (@(posedge rclk) disable iff (mrst)
        (cfg_q.mode == MODE_FWFT && !st_q.valid) |=> (st_q.relbin == $past(st_q.relbin)));

    // R2: the crossing pointer changes one bit at a time
    a_r2_rgray_one_bit: assert property (@(posedge rclk) disable iff (mrst)
        $countones(st_q.relgray ^ $past(st_q.relgray)) <= 1);

    // R7: an empty buffer is always almost empty
    a_r7_empty_is_low: assert property (@(posedge rclk) disable iff (mrst)
        (cfg_q.mode == MODE_STD && st_q.empty) |-> st_q.ae);
endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo #(
    parameter int DW     = 18,
    parameter int AW     = 11,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mrst,
    input  logic          fwft_sel,
    input  logic          def_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          stat_rd,
    output logic          stat_wr,
    output logic          half_full,
    output logic          almost_empty,
    output logic          almost_full,
    input  logic          ae_ld,
    input  logic [AW-1:0] ae_val,
    input  logic          af_ld,
    input  logic [AW-1:0] af_val
);
    localparam int PW = AW + 1;

    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;
    logic [PW-1:0] wgray, wgray_s;
    logic [PW-1:0] relgray, relgray_s;

    dmf_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk  (wr_clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    dmf_sync2 #(.W(PW)) u_sync_w2r (
        .clk  (rd_clk),
        .mrst (mrst),
        .d    (wgray),
        .q    (wgray_s)
    );

    dmf_sync2 #(.W(PW)) u_sync_r2w (
        .clk  (wr_clk),
        .mrst (mrst),
        .d    (relgray),
        .q    (relgray_s)
    );

    dmf_wr_ctl #(.AW(AW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_wr (
        .wclk        (wr_clk),
        .mrst        (mrst),
        .fwft_sel    (fwft_sel),
        .def_sel     (def_sel),
        .wen         (wr_en),
        .af_ld       (af_ld),
        .af_val      (af_val),
        .rgray_s     (relgray_s),
        .we          (we),
        .waddr       (waddr),
        .wgray       (wgray),
        .stat_wr     (stat_wr),
        .half_full   (half_full),
        .almost_full (almost_full)
    );

    dmf_rd_ctl #(.DW(DW), .AW(AW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_rd (
        .rclk         (rd_clk),
        .mrst         (mrst),
        .fwft_sel     (fwft_sel),
        .def_sel      (def_sel),
        .ren          (rd_en),
        .ae_ld        (ae_ld),
        .ae_val       (ae_val),
        .wgray_s      (wgray_s),
        .rdata        (rdata),
        .raddr        (raddr),
        .relgray      (relgray),
        .dout         (rd_data),
        .stat_rd      (stat_rd),
        .almost_empty (almost_empty)
    );
endmodule

// File: tb/dmf_fifo_tb.sv
`timescale 1ns/1ps
module dmf_fifo_tb;
    localparam int DW    = 18;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;

    logic wr_clk = 1'b0;
    logic rclk_a = 1'b0;
    logic sep    = 1'b0;
    logic rd_clk;
    always #5 wr_clk = ~wr_clk;
    always #7 rclk_a = ~rclk_a;
    assign rd_clk = sep ? rclk_a : wr_clk;

    logic          mrst = 1'b1, fwft_sel = 1'b0, def_sel = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, ae_ld = 1'b0, af_ld = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] ae_val = '0, af_val = '0;
    logic [DW-1:0] rd_data;
    logic          stat_rd, stat_wr, half_full, almost_empty, almost_full;

    dmf_fifo #(.DW(DW), .AW(AW)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .fwft_sel(fwft_sel),
        .def_sel(def_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .stat_rd(stat_rd), .stat_wr(stat_wr),
        .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full),
        .ae_ld(ae_ld), .ae_val(ae_val), .af_ld(af_ld), .af_val(af_val)
    );

    int            checks = 0, errors = 0, wseq = 1;
    bit            done = 0, mode_b = 0, pend_std = 0;
    int            ae_b = 127, af_b = 127;
    logic [DW-1:0] q[$];
    logic [DW-1:0] exp_std;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        int n;
        n = q.size();
        chk(req, "stat_rd", stat_rd, mode_b ? (n > 0) : (n == 0));
        chk(req, "stat_wr", stat_wr, mode_b ? (n < DEPTH) : (n == DEPTH));
        chk(req, "half_full", half_full, n > DEPTH / 2);
        chk(req, "almost_empty", almost_empty, n <= ae_b);
        chk(req, "almost_full", almost_full, n >= DEPTH - af_b);
    endtask

    // one read-clock step; compares the output every step it is meaningful
    task automatic rd_cycle(input bit en);
        @(negedge rd_clk);
        if (pend_std) begin
            chk("R3", "standard read data", rd_data, exp_std);
            pend_std = 0;
        end
        rd_en = en;
        #1;
        if (!mode_b) begin
            if (en && !stat_rd) begin
                exp_std  = q.pop_front();
                pend_std = 1;
            end
        end else if (stat_rd) begin
            if (q.size() == 0) chk("R4", "output ready with nothing stored", 1, 0);
            else begin
                chk("R4", "fall-through data", rd_data, q[0]);
                if (en) void'(q.pop_front());
            end
        end
    endtask

    task automatic write_words(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en   = 1'b1;
            wr_data = DW'(wseq * 37 + 11);
            wseq++;
            #1;
            if (!(mode_b ? !stat_wr : stat_wr)) q.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (8) rd_cycle(0);
    endtask

    task automatic fill_to(input int n, input string req);
        write_words(n - q.size());
        settle();
        chk(req, "stored count", q.size(), n);
        chk_flags(req);
    endtask

    task automatic drain_to(input int n);
        while (q.size() > n) rd_cycle(1);
        rd_cycle(0);
    endtask

    task automatic both(input int n);
        fork
            write_words(n);
            begin
                for (int i = 0; i < n; i++) rd_cycle(i % 3 != 2);
                rd_cycle(0);
            end
        join
    endtask

    task automatic do_reset(input bit m, input bit d);
        mrst = 1'b1; fwft_sel = m; def_sel = d;
        wr_en = 1'b0; rd_en = 1'b0; ae_ld = 1'b0; af_ld = 1'b0;
        repeat (6) @(negedge wr_clk);
        q.delete(); pend_std = 0; mode_b = m;
        ae_b = d ? 1023 : 127; af_b = ae_b;
        chk("R10", "stat_rd in reset", stat_rd, m ? 0 : 1);
        chk("R10", "stat_wr in reset", stat_wr, m ? 1 : 0);
        chk("R10", "half_full in reset", half_full, 0);
        chk("R10", "almost_full in reset", almost_full, 0);
        @(negedge wr_clk);
        mrst = 1'b0;
        repeat (4) rd_cycle(0);
        chk_flags("R10");
    endtask

    initial begin
        logic [DW-1:0] d0;
        // standard mode, shared clock, 127 offsets
        do_reset(0, 0);
        write_words(10); settle(); chk_flags("R5");
        drain_to(0); settle(); chk_flags("R5");
        d0 = rd_data;
        repeat (3) rd_cycle(1);
        rd_cycle(0);
        chk("R3", "data after read while empty", rd_data, d0);
        write_words(1); settle(); drain_to(0); settle(); chk_flags("R3");
        fill_to(127, "R8"); fill_to(128, "R8");
        fill_to(1024, "R6"); fill_to(1025, "R6");
        fill_to(1920, "R7"); fill_to(1921, "R7");
        fill_to(2048, "R5");
        write_words(4); settle();
        chk("R1", "count after writes while full", q.size(), DEPTH);
        chk_flags("R1");
        drain_to(1025);
        both(80); settle(); chk_flags("R6");
        drain_to(0); settle(); chk_flags("R2");

        // offset reload
        @(negedge rd_clk); ae_ld = 1'b1; ae_val = AW'(5);
        @(negedge rd_clk); ae_ld = 1'b0; ae_b = 5;
        @(negedge wr_clk); af_ld = 1'b1; af_val = AW'(10);
        @(negedge wr_clk); af_ld = 1'b0; af_b = 10;
        fill_to(5, "R9"); fill_to(6, "R9");
        fill_to(2037, "R9"); fill_to(2038, "R9");
        drain_to(0); settle(); chk_flags("R9");

        // fall-through mode, 1023 offsets
        do_reset(1, 1);
        repeat (3) rd_cycle(1);
        rd_cycle(0);
        chk("R4", "stat_rd after read while not ready", stat_rd, 0);
        write_words(1); settle(); chk_flags("R4");
        rd_cycle(0);
        fill_to(1023, "R8"); fill_to(1024, "R8");
        fill_to(1025, "R7");
        both(60); settle(); chk_flags("R6");
        fill_to(2048, "R5");
        write_words(3); settle();
        chk("R1", "count after writes while no room", q.size(), DEPTH);
        drain_to(0); settle(); chk_flags("R4");

        // unrelated clocks
        sep = 1'b1;
        do_reset(0, 0);
        both(300); drain_to(0); settle(); chk_flags("R2");
        do_reset(1, 0);
        both(300); drain_to(0); settle(); chk_flags("R2");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule